// File: doc/BRIEF.md
# Multi-Channel Event Timer

The block is an event timer that sits behind a single-cycle register bus. It has one free-running main counter and three comparator channels. Each channel compares the counter with its own target. On a match the channel raises its interrupt, either once (one-shot) or at fixed intervals (periodic). In periodic mode a hidden accumulator holds the absolute time of the next fire. After each fire the hardware adds the period to the accumulator, so software does not re-arm the channel.

Software reads the capability word to learn the channel count, the counter width and the tick period. It starts and stops the counter with a global enable and programs each channel through a configuration word and a compare word. A channel can signal in edge mode or in level mode. In edge mode it gives a one-cycle pulse. In level mode it sets a status bit that stays set until software clears it. Each channel has a small sequencer for compare writes, with three states:

- `SEQ_DIRECT`: compare writes load the comparator.
- `SEQ_ACC`: the value-set bit is armed. The next compare write loads the accumulator.
- `SEQ_PERIOD`: the next compare write loads the period.

The sequencer has these transitions:

- Any configuration write moves it to `SEQ_ACC` if the write sets both value-set and periodic. Otherwise the configuration write moves it to `SEQ_DIRECT`.
- In `SEQ_ACC`, a compare write moves it to `SEQ_PERIOD`.
- In `SEQ_PERIOD`, a compare write moves it back to `SEQ_DIRECT`.
- In `SEQ_DIRECT`, the state holds.

Top module: `evt_timer`

Register map (word addresses):

| Address | Register |
|---|---|
| 0 | Capability |
| 1 | Global configuration |
| 2 | Interrupt status |
| 3 | Main counter |
| 4 + 2·i | Channel i configuration |
| 5 + 2·i | Channel i compare |

Bit layouts:

- **Capability word:** bits [4:0] hold the channel count minus one. Bit 13 is 1 for a 64-bit counter. Bits [63:32] hold the tick period in femtoseconds.
- **Global configuration:** bit 0 is the counter enable.
- **Channel configuration:**
  - bit 0: level (1) or edge (0)
  - bit 1: interrupt enable
  - bit 2: periodic (1) or one-shot (0)
  - bit 3: periodic-capable, read-only
  - bit 4: value-set
  - bit 5: force 32-bit

## Requirements
- R1: The capability word at address 0 reads the channel count minus one in bits [4:0]. It reads 1 in bit 13 for a 64-bit counter. It reads the tick period in femtoseconds (default 20000000) in bits [63:32].
- R2: After reset the main counter is 0, the global configuration reads 0 and the status word reads 0. Every channel configuration reads only its periodic-capable bit (bit 3), and all interrupt outputs are low.
- R3: The counter at address 3 advances by one per clock only while global configuration bit 0 is set. A counter write takes effect only while that bit is clear and is ignored while it is set.
- R4: A match occurs when the running counter equals the channel's active target. A one-shot channel with a compare value C fires once, and its interrupt is first seen high while the counter reads C+1.
- R5: In edge mode (configuration bit 0 clear) a match gives a one-cycle interrupt pulse when enable (bit 1) is set, and the status bit is not set.
- R6: When a configuration write sets both periodic (bit 2) and value-set (bit 4), value-set reads back 1. The next compare write loads the accumulator, and value-set then reads back 0. The write after that loads the period. A compare read in periodic mode returns the accumulator.
- R7: In periodic mode every match fires the interrupt and adds the period to the accumulator. An accumulator of A and a period of P give fires seen at counter values A+1, A+P+1 and A+2P+1.
- R8: In level mode (bit 0 set) a match sets the channel's bit in the status word at address 2. The bit stays set until a 1 is written to it. Writing 0, or writing 1 to other bits, leaves it set.
- R9: In level mode the interrupt output equals the status bit ANDed with the channel's enable bit.
- R10: With force 32-bit (bit 5) set, compare writes keep only the low 32 bits and the upper compare bits read as 0. Matching then uses only the low 32 bits of counter and target.
- R11: A channel that is not periodic-capable (channel 2 by default) ignores writes to its periodic bit and stays one-shot.
- R12: Writing the current counter value as the compare value of a one-shot channel while the counter runs produces no fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 64 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 64 | Read data, combinational from reg_addr |
| irq | output | 3 | One interrupt output per channel |

## Verification
Directed scenarios drive channels in three configurations: one-shot edge, periodic via value-set, and level with enable on and off. For each, the bench records the counter value seen at every interrupt cycle. This tells a fire at the match from one a cycle early or late, and a periodic stream from a single fire. Level tests write zero, write ones to other bits, and write the channel's own bit, which tells a write-1-to-clear status from a plain write. Counter writes while running, a target planted at the live counter value, and a 33-bit compare value under 32-bit forcing each target one ignore rule.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    typedef enum logic [1:0] {
        SEQ_DIRECT,
        SEQ_ACC,
        SEQ_PERIOD
    } seq_e;

    localparam int CFG_LEVEL = 0;
    localparam int CFG_IE    = 1;
    localparam int CFG_PER   = 2;
    localparam int CFG_PCAP  = 3;
    localparam int CFG_VSET  = 4;
    localparam int CFG_F32   = 5;

    localparam int A_CAP  = 0;
    localparam int A_GCFG = 1;
    localparam int A_STAT = 2;
    localparam int A_CNT  = 3;
    localparam int A_CH0  = 4;

    localparam int CAP_NCH_W = 5;
    localparam int CAP_W64   = 13;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
        else if (we)
            cnt <= wdata;
    end

    // R3
    count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> cnt == $past(cnt) + 1'b1);
    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !we) |=> $stable(cnt));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter int CNT_W       = 64,
    parameter bit PER_CAPABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_run,
    input  logic             cfg_we,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             stat_clr,
    output logic [CNT_W-1:0] cfg_rd,
    output logic [CNT_W-1:0] cmp_rd,
    output logic             stat,
    output logic             irq
);
    seq_e seq_q, seq_d;
    logic lvl, ie, per, f32, pulse_q;
    logic [CNT_W-1:0] target, acc, wmask, wval, active;
    logic hit, per_new;

    assign per_new = PER_CAPABLE && wdata[CFG_PER];
    assign wmask   = f32 ? CNT_W'(32'hFFFF_FFFF) : '1;
    assign wval    = wdata & wmask;
    assign active  = per ? acc : target;
    assign hit     = cnt_run && ((cnt & wmask) == (active & wmask));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_DIRECT;
        else        seq_q <= seq_d;
    end

    // next state
    always_comb begin
        seq_d = seq_q;
        if (cfg_we) begin
            seq_d = (wdata[CFG_VSET] && per_new) ? SEQ_ACC : SEQ_DIRECT;
        end else begin
            unique case (seq_q)
                SEQ_DIRECT: seq_d = SEQ_DIRECT;
                SEQ_ACC:    if (cmp_we) seq_d = SEQ_PERIOD;
                SEQ_PERIOD: if (cmp_we) seq_d = SEQ_DIRECT;
                default:    seq_d = SEQ_DIRECT;
            endcase
        end
    end

    // configuration, targets and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl     <= 1'b0;
            ie      <= 1'b0;
            per     <= 1'b0;
            f32     <= 1'b0;
            target  <= '0;
            acc     <= '0;
            stat    <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                lvl <= wdata[CFG_LEVEL];
                ie  <= wdata[CFG_IE];
                per <= per_new;
                f32 <= wdata[CFG_F32];
            end
            if (cmp_we) begin
                if (seq_q == SEQ_ACC) acc <= wval;
                else                  target <= wval;
            end else if (hit && per) begin
                acc <= (acc + target) & wmask;
            end
            if (hit && lvl)    stat <= 1'b1;
            else if (stat_clr) stat <= 1'b0;
            pulse_q <= hit && ie && !lvl;
        end
    end

    // outputs
    always_comb begin
        cfg_rd            = '0;
        cfg_rd[CFG_LEVEL] = lvl;
        cfg_rd[CFG_IE]    = ie;
        cfg_rd[CFG_PER]   = per;
        cfg_rd[CFG_PCAP]  = PER_CAPABLE;
        cfg_rd[CFG_VSET]  = (seq_q == SEQ_ACC);
        cfg_rd[CFG_F32]   = f32;
        cmp_rd            = active & wmask;
        irq               = lvl ? (stat && ie) : pulse_q;
    end

    // R6
    vset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd[CFG_VSET] && cmp_we && !cfg_we) |=> !cfg_rd[CFG_VSET]);
    // R8
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !stat_clr) |=> stat);
    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !hit) |=> !stat);
    // R5
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && irq && !cfg_we) |=> !irq);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int          NUM_CH  = 3,
    parameter int          CNT_W   = 64,
    parameter int          AW      = 5,
    parameter logic [31:0] TICK_FS = 32'd20_000_000,
    parameter logic [NUM_CH-1:0] PER_CAP = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic              reg_we,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam logic [AW-1:0] ADDR_GCFG = AW'(A_GCFG);
    localparam logic [AW-1:0] ADDR_STAT = AW'(A_STAT);
    localparam logic [AW-1:0] ADDR_CNT  = AW'(A_CNT);

    logic             run;
    logic [CNT_W-1:0] cnt, cap;
    logic [NUM_CH-1:0] stat;
    logic [CNT_W-1:0] cfg_rd [NUM_CH];
    logic [CNT_W-1:0] cmp_rd [NUM_CH];

    always_ff @(posedge clk) begin
        if (!rst_n)                              run <= 1'b0;
        else if (reg_we && reg_addr == ADDR_GCFG) run <= reg_wdata[0];
    end

    evt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .we    (reg_we && reg_addr == ADDR_CNT),
        .wdata (reg_wdata),
        .cnt   (cnt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [AW-1:0] ADDR_CFG = AW'(A_CH0 + 2 * i);
        localparam logic [AW-1:0] ADDR_CMP = AW'(A_CH0 + 2 * i + 1);
        evt_channel #(.CNT_W(CNT_W), .PER_CAPABLE(PER_CAP[i])) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt),
            .cnt_run  (run),
            .cfg_we   (reg_we && reg_addr == ADDR_CFG),
            .cmp_we   (reg_we && reg_addr == ADDR_CMP),
            .wdata    (reg_wdata),
            .stat_clr (reg_we && reg_addr == ADDR_STAT && reg_wdata[i]),
            .cfg_rd   (cfg_rd[i]),
            .cmp_rd   (cmp_rd[i]),
            .stat     (stat[i]),
            .irq      (irq[i])
        );
    end

    always_comb begin
        cap                     = '0;
        cap[CAP_NCH_W-1:0]      = CAP_NCH_W'(NUM_CH - 1);
        cap[CAP_W64]            = (CNT_W >= 64);
        cap[CNT_W-1 -: 32]      = TICK_FS;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(A_CAP))    reg_rdata = cap;
        else if (reg_addr == ADDR_GCFG) reg_rdata = CNT_W'(run);
        else if (reg_addr == ADDR_STAT) reg_rdata = CNT_W'(stat);
        else if (reg_addr == ADDR_CNT)  reg_rdata = cnt;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == AW'(A_CH0 + 2 * i))     reg_rdata = cfg_rd[i];
            if (reg_addr == AW'(A_CH0 + 2 * i + 1)) reg_rdata = cmp_rd[i];
        end
    end
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic        we = 1'b0;
    logic [63:0] rdata;
    logic [2:0]  irq;

    int checks = 0;
    int failures = 0;
    logic [63:0] seen [8];
    int nseen;

    always #10 clk = ~clk;

    evt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata),
        .reg_we(we), .reg_rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic setup(input logic [63:0] c);
        wr(5'd1, 64'd0);
        wr(5'd3, c);
        wr(5'd2, 64'h7);
    endtask

    task automatic watch(input int ch, input int ncyc);
        logic [63:0] v;
        nseen = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            rd(5'd3, v);
            if (irq[ch]) begin
                if (nseen < 8) seen[nseen] = v;
                nseen++;
            end
        end
    endtask

    task automatic t_reset;
        logic [63:0] v;
        rd(5'd0, v);
        chk("R1 channels-1", 64'(v[4:0]), 64'd2);
        chk("R1 64-bit flag", 64'(v[13]), 64'd1);
        chk("R1 tick period", 64'(v[63:32]), 64'd20000000);
        rd(5'd3, v); chk("R2 counter", v, 64'd0);
        rd(5'd1, v); chk("R2 global cfg", v, 64'd0);
        rd(5'd2, v); chk("R2 status", v, 64'd0);
        rd(5'd4, v); chk("R2 ch0 cfg", v, 64'h08);
        rd(5'd8, v); chk("R2 ch2 cfg", v, 64'h00);
        chk("R2 irq", 64'(irq), 64'd0);
    endtask

    task automatic t_counter;
        logic [63:0] v0, v1;
        repeat (5) @(negedge clk);
        rd(5'd3, v0); chk("R3 idle counter", v0, 64'd0);
        wr(5'd3, 64'd100);
        rd(5'd3, v0); chk("R3 write while disabled", v0, 64'd100);
        wr(5'd1, 64'd1);
        rd(5'd3, v0);
        repeat (10) @(negedge clk);
        rd(5'd3, v1); chk("R3 advance 10", v1 - v0, 64'd10);
        wr(5'd3, 64'd5);
        rd(5'd3, v0); chk("R3 write while running ignored", v0, v1 + 64'd1);
        wr(5'd1, 64'd0);
    endtask

    task automatic t_oneshot;
        logic [63:0] v;
        setup(64'd0);
        wr(5'd4, 64'h02);
        wr(5'd5, 64'd20);
        rd(5'd5, v); chk("R4 compare readback", v, 64'd20);
        wr(5'd1, 64'd1);
        watch(0, 40);
        chk("R5 single pulse", 64'(nseen), 64'd1);
        chk("R4 fire at C+1", seen[0], 64'd21);
        rd(5'd2, v); chk("R5 no status in edge mode", v, 64'd0);
        wr(5'd1, 64'd0);
        wr(5'd4, 64'h00);
    endtask

    task automatic t_periodic;
        logic [63:0] v;
        setup(64'd0);
        wr(5'd6, 64'h16);
        rd(5'd6, v); chk("R6 value-set armed", v, 64'h1E);
        wr(5'd7, 64'd30);
        rd(5'd6, v); chk("R6 value-set cleared", v, 64'h0E);
        wr(5'd7, 64'd10);
        rd(5'd7, v); chk("R6 accumulator read", v, 64'd30);
        wr(5'd1, 64'd1);
        watch(1, 70);
        chk("R7 pulse count", 64'(nseen), 64'd4);
        chk("R7 first fire", seen[0], 64'd31);
        chk("R7 second fire", seen[1], 64'd41);
        chk("R7 third fire", seen[2], 64'd51);
        wr(5'd1, 64'd0);
        wr(5'd6, 64'h00);
    endtask

    task automatic t_level;
        logic [63:0] v;
        setup(64'd0);
        wr(5'd4, 64'h03);
        wr(5'd5, 64'd5);
        wr(5'd1, 64'd1);
        repeat (20) @(negedge clk);
        wr(5'd1, 64'd0);
        rd(5'd2, v); chk("R8 status set", v, 64'h1);
        chk("R9 level irq", 64'(irq[0]), 64'd1);
        wr(5'd2, 64'h0);
        rd(5'd2, v); chk("R8 write 0 ignored", v, 64'h1);
        wr(5'd2, 64'h6);
        rd(5'd2, v); chk("R8 other bits ignored", v, 64'h1);
        wr(5'd2, 64'h1);
        rd(5'd2, v); chk("R8 write 1 clears", v, 64'h0);
        chk("R9 irq drops", 64'(irq[0]), 64'd0);
        setup(64'd0);
        wr(5'd4, 64'h01);
        wr(5'd1, 64'd1);
        repeat (20) @(negedge clk);
        wr(5'd1, 64'd0);
        rd(5'd2, v); chk("R9 status without enable", v, 64'h1);
        chk("R9 irq masked", 64'(irq[0]), 64'd0);
        wr(5'd4, 64'h03);
        chk("R9 irq follows enable", 64'(irq[0]), 64'd1);
        wr(5'd2, 64'h1);
        wr(5'd4, 64'h00);
    endtask

    task automatic t_force32;
        logic [63:0] v;
        setup(64'h2_0000_0000);
        wr(5'd4, 64'h22);
        wr(5'd5, 64'h1_0000_0010);
        rd(5'd5, v); chk("R10 upper bits zero", v, 64'h10);
        wr(5'd1, 64'd1);
        watch(0, 30);
        chk("R10 pulse count", 64'(nseen), 64'd1);
        chk("R10 low-bit match", seen[0], 64'h2_0000_0011);
        wr(5'd1, 64'd0);
        wr(5'd4, 64'h00);
    endtask

    task automatic t_noncap;
        logic [63:0] v;
        setup(64'd0);
        wr(5'd8, 64'h16);
        rd(5'd8, v); chk("R11 periodic bit ignored", v, 64'h02);
        wr(5'd9, 64'd8);
        wr(5'd1, 64'd1);
        watch(2, 40);
        chk("R11 one-shot only", 64'(nseen), 64'd1);
        chk("R11 fire time", seen[0], 64'd9);
        wr(5'd1, 64'd0);
        wr(5'd8, 64'h00);
    endtask

    task automatic t_quiet;
        logic [63:0] v;
        setup(64'd0);
        wr(5'd4, 64'h02);
        wr(5'd5, 64'd1000);
        wr(5'd1, 64'd1);
        repeat (5) @(negedge clk);
        rd(5'd3, v);
        wr(5'd5, v);
        watch(0, 50);
        chk("R12 no spurious fire", 64'(nseen), 64'd0);
        wr(5'd1, 64'd0);
        wr(5'd2, 64'h1);
        rd(5'd2, v); chk("R12 status clean", v, 64'd0);
        wr(5'd4, 64'h00);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_counter;
        t_oneshot;
        t_periodic;
        t_level;
        t_force32;
        t_noncap;
        t_quiet;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule